// File: doc/BRIEF.md
# AFSK Tone Modulator with Flag Framing

This block turns a stream of bytes into 8-bit unsigned audio samples for a 1200 bit/s frequency-shift-keyed link. The line uses two tones: mark at 1200 Hz and space at 2200 Hz. Bits are NRZI coded onto the tones, so a 0 changes the tone and a 1 keeps it. A phase-accumulating oscillator makes the waveform. It stores only a quarter of a sine period and rebuilds the rest by mirroring the index and inverting the value.

A start request opens a frame. The block first sends a run of flag bytes, then data bytes taken from a valid/ready stream. When the stream runs dry it sends a run of closing flags and then goes idle. Ordinary bytes get HDLC-style bit stuffing. A flag-valued or abort-valued byte taken straight from the stream goes out unstuffed. An escape byte is not sent; it forces the byte after it out as stuffed data. One `sample_tick_i` pulse produces one output sample. Each tick is handled on two clock edges, so the byte after an escape can be taken on the edge after the tick.

Top module: `afsk_tx_mod`

## Requirements
- R1: After reset `busy_o` is 0, `sample_o` is 0x80 and `in_ready_o` is 0.
- R2: The quarter table entry i (0..127) is floor(128 + 127·sin(2πi/512)). For a phase p in 0..511, let q = p mod 256. The index is q when q < 128 and 255 − q otherwise. The output is the entry when p < 256 and 255 minus the entry when p ≥ 256.
- R3: Each sample first settles the tone, then adds the tone's step to the phase modulo 512, and outputs the sine of the new phase. The mark step is round(512·1200/SAMPLE_RATE) and the space step is round(512·2200/SAMPLE_RATE). Every bit lasts SAMPLE_RATE/1200 samples. A frame starts at phase 0 on the mark tone.
- R4: Bits leave each byte LSB first. A 1 keeps the tone and a 0 switches to the other tone.
- R5: Before any stream byte is taken, round(PREAMBLE_MS·1200/8000) flag bytes 0x7E are sent unstuffed.
- R6: A stream byte equal to 0x7E or 0x7F is sent unstuffed. Any other non-escape byte is sent stuffed.
- R7: In a stuffed byte, after five consecutive 1s a stuffed 0 (a tone switch lasting one bit time) is inserted before the next bit. A 0 bit or a stuffed bit clears the ones count. At a byte boundary the count is cleared only if the previous byte was unstuffed.
- R8: The escape byte 0x1B is never sent. The stream byte after it is sent stuffed, whatever its value. If no byte is valid on the edge after the escape is taken, the frame stops.
- R9: If the stream is empty at a byte boundary, a closing flag 0x7E is sent for each of round(TRAILER_MS·1200/8000) boundaries. Once that count is used up, the next boundary with an empty stream stops the frame: `busy_o` falls and `sample_o` becomes 0x80.
- R10: Timing of the handshake and samples:
  - `in_ready_o` is high only on a tick cycle at a byte boundary after the preamble, or on the cycle after an escape was taken.
  - `sample_o` changes on the second clock edge after `sample_tick_i`.
  - `sample_tick_i` must be low on the cycle that follows a tick.
- R11: While `busy_o` is low, `sample_o` stays 0x80 and ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a frame when idle |
| sample_tick_i | input | 1 | One pulse per output sample |
| in_valid_i | input | 1 | Stream byte present |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Stream byte taken this edge when valid |
| sample_o | output | 8 | Unsigned audio sample |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with a 9600 samples/s rate, which gives 8 samples per bit and phase steps of 64 and 117. It uses a 20 ms preamble and a 10 ms trailer, which give 3 opening and 2 closing flags. These short frames let many frames run in turn: runs of ones that force stuffing, flag- and abort-valued data, escapes of flags and of the escape itself, a ones run carried into an unstuffed byte, and an escape left dangling at the end. The quarter-wave unit is also driven on its own through all 512 phases.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

    localparam int PHASE_BITS = 9;
    localparam int PHASE_LEN  = 1 << PHASE_BITS;
    localparam int QUARTER    = PHASE_LEN / 4;
    localparam int BAUD       = 1200;
    localparam int MARK_HZ    = 1200;
    localparam int SPACE_HZ   = 2200;

    localparam logic [7:0] FLAG_BYTE  = 8'h7E;
    localparam logic [7:0] ESC_BYTE   = 8'h1B;
    localparam logic [7:0] ABORT_BYTE = 8'h7F;

    typedef enum logic {
        TONE_MARK  = 1'b0,
        TONE_SPACE = 1'b1
    } tone_e;

    // rounded phase step per sample for a tone
    function automatic int tone_step(int hz, int rate);
        return (PHASE_LEN * hz + rate / 2) / rate;
    endfunction

    // rounded byte count for a duration in milliseconds
    function automatic int ms_to_bytes(int ms);
        return (ms * BAUD + 4000) / 8000;
    endfunction

    function automatic int quarter_entry(int i);
        real ang;
        ang = 2.0 * 3.141592653589793 * real'(i) / real'(PHASE_LEN);
        return int'($floor(128.0 + 127.0 * $sin(ang)));
    endfunction

endpackage

// File: rtl/afsk_quarter_sine.sv
module afsk_quarter_sine
    import afsk_pkg::*;
(
    input  logic [PHASE_BITS-1:0] phase_i,
    output logic [7:0]            sample_o
);
    localparam int QW = PHASE_BITS - 2;

    logic [7:0]    qtab [QUARTER];
    logic [QW-1:0] fold;
    logic [7:0]    mag;

    for (genvar g = 0; g < QUARTER; g++) begin : g_qtab
        localparam int VAL = quarter_entry(g);
        assign qtab[g] = 8'(VAL);
    end

    always_comb begin
        // second quarter of each half reads the table backwards
        fold     = phase_i[QW] ? ~phase_i[QW-1:0] : phase_i[QW-1:0];
        mag      = qtab[fold];
        // second half is the inverted first half
        sample_o = phase_i[PHASE_BITS-1] ? ~mag : mag;
    end

endmodule

// File: rtl/afsk_nco.sv
module afsk_nco
    import afsk_pkg::*;
#(
    parameter int SAMPLE_RATE = 9600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       step_i,
    input  logic       space_i,
    output logic [7:0] sample_o
);
    localparam logic [PHASE_BITS-1:0] INC_MARK  = PHASE_BITS'(tone_step(MARK_HZ, SAMPLE_RATE));
    localparam logic [PHASE_BITS-1:0] INC_SPACE = PHASE_BITS'(tone_step(SPACE_HZ, SAMPLE_RATE));

    typedef struct packed {
        logic [PHASE_BITS-1:0] phase;
        logic [7:0]            sample;
    } nco_t;

    nco_t                  nco_d, nco_q;
    logic [PHASE_BITS-1:0] phase_nxt;
    logic [7:0]            sine_val;

    afsk_quarter_sine u_sine (
        .phase_i  (phase_nxt),
        .sample_o (sine_val)
    );

    always_comb begin
        nco_d     = nco_q;
        // natural wrap of the accumulator is the modulo
        phase_nxt = nco_q.phase + (space_i ? INC_SPACE : INC_MARK);
        if (clear_i) begin
            nco_d.phase  = '0;
            nco_d.sample = 8'h80;
        end else if (step_i) begin
            nco_d.phase  = phase_nxt;
            nco_d.sample = sine_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nco_q.phase  <= '0;
            nco_q.sample <= 8'h80;
        end else begin
            nco_q <= nco_d;
        end
    end

    assign sample_o = nco_q.sample;

    // R2: a phase in the lower half never yields a sample below mid scale
    p_upper_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nco_q.phase[PHASE_BITS-1] == 1'b0) |-> (nco_q.sample >= 8'h80));

endmodule

// File: rtl/afsk_framer.sv
module afsk_framer
    import afsk_pkg::*;
#(
    parameter int SAMPLE_RATE = 9600,
    parameter int PREAMBLE_MS = 300,
    parameter int TRAILER_MS  = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       tick_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_data_i,
    output logic       in_ready_o,
    output logic       busy_o,
    output logic       step_o,
    output logic       clear_o,
    output logic       space_o
);
    localparam int SPB   = SAMPLE_RATE / BAUD;
    localparam int PRE_N = ms_to_bytes(PREAMBLE_MS);
    localparam int TRL_N = ms_to_bytes(TRAILER_MS);
    localparam int PW    = $clog2(PRE_N + 2);
    localparam int TW    = $clog2(TRL_N + 2);
    localparam int SW    = $clog2(SPB + 1);

    if (SAMPLE_RATE % BAUD != 0) begin : g_bad_rate
        $error("sample rate must be a whole multiple of the bit rate");
    end

    typedef struct packed {
        logic          active;
        logic          half_b;    // second edge of a tick pending
        logic          esc_wait;  // escape taken, follower due
        logic          loaded;    // byte holds unsent bits
        logic [7:0]    cur;
        logic [2:0]    bit_idx;
        logic          stuff_en;
        logic [2:0]    ones;
        logic [PW-1:0] pre;
        logic [TW-1:0] trl;
        tone_e         tone;
        logic [SW-1:0] smp;
    } fr_t;

    fr_t        fr_d, fr_q;
    logic       ready_c, step_c, clear_c, abort_c;
    logic [7:0] byte_v;

    function automatic tone_e other(tone_e t);
        return (t == TONE_MARK) ? TONE_SPACE : TONE_MARK;
    endfunction

    always_comb begin
        fr_d    = fr_q;
        ready_c = 1'b0;
        step_c  = 1'b0;
        clear_c = 1'b0;
        abort_c = 1'b0;
        byte_v  = fr_q.cur;

        if (!fr_q.active) begin
            if (start_i) begin
                fr_d.active   = 1'b1;
                fr_d.half_b   = 1'b0;
                fr_d.esc_wait = 1'b0;
                fr_d.loaded   = 1'b0;
                fr_d.stuff_en = 1'b0;
                fr_d.ones     = '0;
                fr_d.pre      = PW'(PRE_N);
                fr_d.trl      = TW'(TRL_N);
                fr_d.tone     = TONE_MARK;
                fr_d.smp      = '0;
                clear_c       = 1'b1;
            end
        end else if (!fr_q.half_b) begin
            // first edge of a tick: choose the next byte at a boundary
            if (tick_i) begin
                fr_d.half_b = 1'b1;
                if (fr_q.smp == '0 && !fr_q.loaded) begin
                    ready_c = (fr_q.pre == '0);
                    if (!in_valid_i && fr_q.trl == '0) begin
                        fr_d.active = 1'b0;
                        fr_d.half_b = 1'b0;
                        clear_c     = 1'b1;
                    end else begin
                        if (!fr_q.stuff_en) fr_d.ones = '0;
                        fr_d.stuff_en = 1'b1;
                        fr_d.loaded   = 1'b1;
                        fr_d.bit_idx  = '0;
                        if (fr_q.pre != '0) begin
                            fr_d.pre      = fr_q.pre - 1'b1;
                            fr_d.cur      = FLAG_BYTE;
                            fr_d.stuff_en = 1'b0;
                        end else if (in_valid_i) begin
                            if (in_data_i == ESC_BYTE) begin
                                fr_d.esc_wait = 1'b1;
                            end else begin
                                fr_d.cur      = in_data_i;
                                fr_d.stuff_en = !(in_data_i == FLAG_BYTE ||
                                                  in_data_i == ABORT_BYTE);
                            end
                        end else begin
                            fr_d.trl      = fr_q.trl - 1'b1;
                            fr_d.cur      = FLAG_BYTE;
                            fr_d.stuff_en = 1'b0;
                        end
                    end
                end
            end
        end else begin
            // second edge: resolve escape, decide the tone, step the oscillator
            fr_d.half_b = 1'b0;
            if (fr_q.esc_wait) begin
                ready_c = 1'b1;
                if (in_valid_i) begin
                    byte_v        = in_data_i;
                    fr_d.cur      = in_data_i;
                    fr_d.esc_wait = 1'b0;
                end else begin
                    abort_c = 1'b1;
                end
            end
            if (abort_c) begin
                fr_d.active   = 1'b0;
                fr_d.esc_wait = 1'b0;
                fr_d.loaded   = 1'b0;
                clear_c       = 1'b1;
            end else begin
                step_c = 1'b1;
                if (fr_q.smp == '0) begin
                    if (fr_q.stuff_en && fr_q.ones >= 3'd5) begin
                        fr_d.ones = '0;
                        fr_d.tone = other(fr_q.tone);
                    end else begin
                        if (byte_v[fr_q.bit_idx]) begin
                            fr_d.ones = (fr_q.ones == 3'd7) ? fr_q.ones : fr_q.ones + 3'd1;
                        end else begin
                            fr_d.ones = '0;
                            fr_d.tone = other(fr_q.tone);
                        end
                        fr_d.bit_idx = fr_q.bit_idx + 3'd1;
                        if (fr_q.bit_idx == 3'd7) fr_d.loaded = 1'b0;
                    end
                    fr_d.smp = SW'(SPB - 1);
                end else begin
                    fr_d.smp = fr_q.smp - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{active: 1'b0, half_b: 1'b0, esc_wait: 1'b0, loaded: 1'b0,
                      cur: '0, bit_idx: '0, stuff_en: 1'b0, ones: '0,
                      pre: '0, trl: '0, tone: TONE_MARK, smp: '0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign in_ready_o = ready_c;
    assign busy_o     = fr_q.active;
    assign step_o     = step_c;
    assign clear_o    = clear_c;
    assign space_o    = (fr_d.tone == TONE_SPACE);

    // R7: a stuffed byte never carries more than five ones in a row
    p_ones_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.stuff_en |-> (fr_q.ones <= 3'd5));

    // R3: within a frame the tone only moves at the start of a bit time
    p_tone_at_bit_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.active && $past(fr_q.active) && fr_q.tone != $past(fr_q.tone))
        |-> $past(fr_q.half_b && fr_q.smp == '0));

    // R8: a pending escape is always resolved on the second edge of its tick
    p_escape_resolved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.esc_wait |-> fr_q.half_b);

    // R10: bytes are taken only at a bit-time boundary
    p_take_at_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (fr_q.smp == '0));

endmodule

// File: rtl/afsk_tx_mod.sv
module afsk_tx_mod #(
    parameter int SAMPLE_RATE = 9600,
    parameter int PREAMBLE_MS = 300,
    parameter int TRAILER_MS  = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       sample_tick_i,
    input  logic       in_valid_i,
    input  logic [7:0] in_data_i,
    output logic       in_ready_o,
    output logic [7:0] sample_o,
    output logic       busy_o
);
    logic step, clear, space;

    afsk_framer #(
        .SAMPLE_RATE (SAMPLE_RATE),
        .PREAMBLE_MS (PREAMBLE_MS),
        .TRAILER_MS  (TRAILER_MS)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tick_i     (sample_tick_i),
        .in_valid_i (in_valid_i),
        .in_data_i  (in_data_i),
        .in_ready_o (in_ready_o),
        .busy_o     (busy_o),
        .step_o     (step),
        .clear_o    (clear),
        .space_o    (space)
    );

    afsk_nco #(
        .SAMPLE_RATE (SAMPLE_RATE)
    ) u_nco (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .step_i   (step),
        .space_i  (space),
        .sample_o (sample_o)
    );

    // R11: an idle modulator rests at mid scale
    p_idle_mid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sample_o == 8'h80));

endmodule

// File: tb/tb_afsk_tx_mod.sv
`timescale 1ns/1ps
module tb_afsk_tx_mod;

    localparam int SR      = 9600;
    localparam int PRE_MS  = 20;
    localparam int TRL_MS  = 10;
    localparam int SPB     = SR / 1200;
    localparam int PRE_N   = (PRE_MS * 1200 + 4000) / 8000;
    localparam int TRL_N   = (TRL_MS * 1200 + 4000) / 8000;
    localparam int STEP_M  = (512 * 1200 + SR / 2) / SR;
    localparam int STEP_S  = (512 * 2200 + SR / 2) / SR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       sample_tick_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_ready_o;
    logic [7:0] sample_o;
    logic       busy_o;

    logic [8:0] t_phase = '0;
    logic [7:0] t_sample;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] src[$];
    int         idx;
    int         exp_q[$];
    int         m_phase, m_tone, m_ones;
    bit         m_prev_stuffed;

    always #2.5 clk = ~clk;

    afsk_tx_mod #(
        .SAMPLE_RATE (SR),
        .PREAMBLE_MS (PRE_MS),
        .TRAILER_MS  (TRL_MS)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .sample_tick_i (sample_tick_i),
        .in_valid_i    (in_valid_i),
        .in_data_i     (in_data_i),
        .in_ready_o    (in_ready_o),
        .sample_o      (sample_o),
        .busy_o        (busy_o)
    );

    afsk_quarter_sine u_sine_alone (
        .phase_i  (t_phase),
        .sample_o (t_sample)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int ref_sine(int p);
        int q, k, t;
        q = p % 256;
        k = (q < 128) ? q : 255 - q;
        t = int'($floor(128.0 + 127.0 * $sin(2.0 * 3.141592653589793 * real'(k) / 512.0)));
        return (p < 256) ? t : 255 - t;
    endfunction

    // one bit time of expected samples
    task automatic m_emit();
        for (int s = 0; s < SPB; s++) begin
            m_phase = (m_phase + (m_tone != 0 ? STEP_S : STEP_M)) % 512;
            exp_q.push_back(ref_sine(m_phase));
        end
    endtask

    task automatic m_byte(input logic [7:0] b, input bit stuffed);
        if (!m_prev_stuffed) m_ones = 0;
        for (int i = 0; i < 8; i++) begin
            if (stuffed && m_ones >= 5) begin
                m_ones = 0;
                m_tone ^= 1;
                m_emit();
            end
            if (b[i]) m_ones++;
            else begin
                m_ones = 0;
                m_tone ^= 1;
            end
            m_emit();
        end
        m_prev_stuffed = stuffed;
    endtask

    task automatic build_expected();
        int  k;
        bit  cut;
        exp_q.delete();
        m_phase = 0; m_tone = 0; m_ones = 0; m_prev_stuffed = 1'b0;
        cut = 1'b0;
        for (int p = 0; p < PRE_N; p++) m_byte(8'h7E, 1'b0);
        k = 0;
        while (k < src.size()) begin
            if (src[k] == 8'h1B) begin
                if (k + 1 < src.size()) begin
                    m_byte(src[k+1], 1'b1);
                    k += 2;
                end else begin
                    cut = 1'b1;
                    k++;
                end
            end else begin
                m_byte(src[k], !(src[k] == 8'h7E || src[k] == 8'h7F));
                k++;
            end
            if (cut) break;
        end
        if (!cut) for (int t = 0; t < TRL_N; t++) m_byte(8'h7E, 1'b0);
    endtask

    // one clock cycle of stimulus; stream handshake recorded before the edge
    task automatic cyc(input bit tk, input bit st);
        bit hs;
        @(negedge clk);
        sample_tick_i = tk;
        start_i       = st;
        in_valid_i    = (idx < src.size());
        in_data_i     = (idx < src.size()) ? src[idx] : 8'h00;
        #1;
        hs = in_valid_i && in_ready_o;
        @(posedge clk);
        #1;
        if (hs) idx++;
    endtask

    task automatic one_sample();
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        @(negedge clk);
        #1;
    endtask

    task automatic run_frame(input string tag);
        int n;
        build_expected();
        idx = 0;
        cyc(1'b0, 1'b1);
        @(negedge clk);
        #1;
        chk(busy_o == 1'b1 && sample_o == 8'h80, "R3", {tag, " start state"},
            {busy_o, sample_o}, {1'b1, 8'h80});
        n = 0;
        foreach (exp_q[e]) begin
            one_sample();
            chk(sample_o == 8'(exp_q[e]) && busy_o, "R4", {tag, " sample"},
                sample_o, exp_q[e]);
            chk(in_ready_o == 1'b0, "R10", {tag, " ready off-tick"}, in_ready_o, 0);
            n++;
            if (n == PRE_N * 8 * SPB)
                chk(idx == 0, "R5", {tag, " nothing taken in preamble"}, idx, 0);
        end
        one_sample();
        chk(busy_o == 1'b0 && sample_o == 8'h80, "R9", {tag, " frame end"},
            {busy_o, sample_o}, {1'b0, 8'h80});
        chk(idx == src.size(), "R8", {tag, " bytes consumed"}, idx, src.size());
        src.delete();
        idx = 0;
    endtask

    initial begin
        int seed_dummy;
        int len;
        seed_dummy = $urandom(32'd20240);
        idx = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        chk(sample_o == 8'h80, "R1", "sample after reset", sample_o, 128);
        chk(in_ready_o == 1'b0, "R1", "ready after reset", in_ready_o, 0);

        // R11 ticks while idle change nothing
        src.push_back(8'h55);
        for (int i = 0; i < 4; i++) begin
            one_sample();
            chk(busy_o == 1'b0 && sample_o == 8'h80 && idx == 0, "R11",
                "idle tick", sample_o, 128);
        end
        src.delete();
        idx = 0;

        // R2 whole sine wave, each phase
        for (int p = 0; p < 512; p++) begin
            t_phase = 9'(p);
            #1;
            chk(t_sample == 8'(ref_sine(p)), "R2", "sine at phase", t_sample, ref_sine(p));
        end

        // R5 R9 empty frame: flags only
        run_frame("empty");

        // R7 long ones forcing stuffed bits
        src = '{8'hFF, 8'hFF};
        run_frame("ones-run");

        // R6 flag and abort values sent as is
        src = '{8'h7E, 8'h55, 8'h7F};
        run_frame("raw-flag");

        // R8 escaped flag and escaped escape
        src = '{8'h1B, 8'h7E, 8'h1B, 8'h1B, 8'h1B, 8'h7F};
        run_frame("escaped");

        // R7 ones run carried into an unstuffed byte, then reset
        src = '{8'hF8, 8'h7F, 8'h0F, 8'hFF};
        run_frame("carry");

        // R8 dangling escape stops the frame
        src = '{8'h3C, 8'h1B};
        run_frame("dangling-esc");

        // mixed random frames
        for (int f = 0; f < 8; f++) begin
            len = int'($urandom % 9);
            for (int b = 0; b < len; b++) begin
                case ($urandom % 8)
                    0: src.push_back(8'h7E);
                    1: src.push_back(8'h7F);
                    2: src.push_back(8'h1B);
                    3: src.push_back(8'hFF);
                    default: src.push_back(8'($urandom));
                endcase
            end
            run_frame("random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule